// File: doc/BRIEF.md
# Signed-Digit Recoder for Decimal Multiplier Operands

This block takes a multiplier operand made of BCD digits and rewrites every digit as a signed digit between -5 and +5. Each output digit is a sign flag plus five select lines, and at most one select line is high. A line that is high picks a magnitude from one to five, so a partial product generator downstream only needs the multiples 0 to 5 of the multiplicand. For negative digits it inverts the chosen multiple.

Rewriting a large digit as a negative value sends a unit of ten to the next higher position. That unit is added to the next digit before it is recoded. The unit leaving the top position comes out as a separate carry, whose weight is ten to the power of the digit count. The block is purely combinational, and the digit count is a parameter.

Top module: `decimal_digit_recoder`

## Requirements
- R1: Every recoded digit has a value in [-5, +5].
- R2: Magnitude select line k (bit k-1 of a digit's 5-bit field, digit i occupying bits 5i+4..5i) is high exactly when the digit's magnitude is k, for k from 1 to 5. At most one line of a digit is high.
- R3: A digit whose value is zero drives all five select lines low and its sign flag low.
- R4: The sign flag of digit i (bit i of the sign bus) is high exactly when the digit's value is negative.
- R5: At each position, let t be the input digit plus the incoming transfer. If t is 6 or greater, the digit is t-10 and the outgoing transfer is 1. Otherwise the digit is t and the outgoing transfer is 0.
- R6: The least significant position has an incoming transfer of 0.
- R7: The top carry equals the transfer out of the most significant position. The sum of all digit values times 10^i, plus the top carry times 10^n, equals the decimal value of the input.
- R8: Input digit i occupies bits 4i+3..4i, with digit 0 as the least significant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bcd_in | input | 4*NDIG | Multiplier operand, one BCD digit per nibble |
| dig_neg | output | NDIG | Sign flag of each recoded digit |
| dig_sel | output | 5*NDIG | One-hot magnitude select lines of each digit |
| carry_top | output | 1 | Transfer out of the top digit, weight 10^NDIG |

## Verification
The embedded checks assume that every input nibble is a legal BCD code from 0 to 9. Each check tests this condition itself and stays silent on nibbles 10 to 15, because the recoding of those codes is unspecified. The stimulus builds every operand from decimal digits. It walks all 10^4 legal values, so no illegal nibble is ever driven and every transfer chain pattern occurs.

// File: rtl/dec_recode_pkg.sv
package dec_recode_pkg;
   localparam int BCD_W      = 4;
   localparam int MAG_W      = 5;
   localparam int MAG_BIN_W  = 3;
   localparam int XFER_LIMIT = 6;
   localparam int RADIX      = 10;
endpackage

// File: rtl/sdr_mag_onehot.sv
module sdr_mag_onehot
   import dec_recode_pkg::*;
#(
   parameter int LINES = MAG_W
) (
   input  logic [MAG_BIN_W-1:0] mag_bin,
   output logic [LINES-1:0]     mag_hot
);
   if (LINES < 1 || LINES >= (1 << MAG_BIN_W)) begin : g_bad_lines
      $error("sdr_mag_onehot: LINES out of range");
   end

   for (genvar k = 0; k < LINES; k++) begin : g_line
      assign mag_hot[k] = (mag_bin == MAG_BIN_W'(k + 1));
   end

   always_comb begin
      assert_sel_onehot_R2: assert ($onehot0(mag_hot))
         else $error("select lines not one-hot");
   end
endmodule

// File: rtl/sdr_digit_slice.sv
module sdr_digit_slice
   import dec_recode_pkg::*;
(
   input  logic [BCD_W-1:0] bcd_digit,
   input  logic             xfer_in,
   output logic             sign_neg,
   output logic [MAG_W-1:0] mag_hot,
   output logic             xfer_out
);
   logic [BCD_W:0]       total;
   logic [MAG_BIN_W-1:0] mag_bin;

   always_comb begin
      total = {1'b0, bcd_digit} + {{BCD_W{1'b0}}, xfer_in};
      if (total >= (BCD_W+1)'(XFER_LIMIT)) begin
         xfer_out = 1'b1;
         mag_bin  = MAG_BIN_W'((BCD_W+1)'(RADIX) - total);
         sign_neg = (total != (BCD_W+1)'(RADIX));
      end else begin
         xfer_out = 1'b0;
         mag_bin  = MAG_BIN_W'(total);
         sign_neg = 1'b0;
      end
   end

   sdr_mag_onehot #(.LINES(MAG_W)) u_hot (
      .mag_bin (mag_bin),
      .mag_hot (mag_hot)
   );

   // Value seen from the one-hot lines, for the checks below
   int unsigned hot_mag;
   always_comb begin
      hot_mag = 0;
      for (int k = 0; k < MAG_W; k++)
         if (mag_hot[k]) hot_mag = k + 1;
   end

   always_comb begin
      if (bcd_digit <= BCD_W'(RADIX - 1)) begin
         assert_zero_clean_R3: assert (mag_hot != '0 || !sign_neg)
            else $error("zero digit carries a sign");
         assert_position_value_R5: assert (
            (int'(xfer_out) * RADIX + (sign_neg ? -int'(hot_mag) : int'(hot_mag)))
               == int'(bcd_digit) + int'(xfer_in))
            else $error("slice does not preserve value");
      end
   end
endmodule

// File: rtl/decimal_digit_recoder.sv
module decimal_digit_recoder
   import dec_recode_pkg::*;
#(
   parameter int NDIG = 4
) (
   input  logic [BCD_W*NDIG-1:0] bcd_in,
   output logic [NDIG-1:0]       dig_neg,
   output logic [MAG_W*NDIG-1:0] dig_sel,
   output logic                  carry_top
);
   if (NDIG < 1 || NDIG > 16) begin : g_bad_ndig
      $error("decimal_digit_recoder: NDIG must be 1..16");
   end

   logic [NDIG:0] xfer;
   assign xfer[0]   = 1'b0;   // R6
   assign carry_top = xfer[NDIG];

   for (genvar i = 0; i < NDIG; i++) begin : g_pos
      sdr_digit_slice u_slice (
         .bcd_digit (bcd_in[BCD_W*i +: BCD_W]),
         .xfer_in   (xfer[i]),
         .sign_neg  (dig_neg[i]),
         .mag_hot   (dig_sel[MAG_W*i +: MAG_W]),
         .xfer_out  (xfer[i+1])
      );
   end

   // Whole-operand reconstruction from the ports
   logic        all_bcd;
   longint      in_val;
   longint      out_val;
   longint      wt;
   always_comb begin
      all_bcd = 1'b1;
      in_val  = 0;
      out_val = 0;
      wt      = 1;
      for (int i = 0; i < NDIG; i++) begin
         int m;
         m = 0;
         if (bcd_in[BCD_W*i +: BCD_W] > BCD_W'(RADIX - 1)) all_bcd = 1'b0;
         for (int k = 0; k < MAG_W; k++)
            if (dig_sel[MAG_W*i + k]) m = k + 1;
         in_val  += wt * longint'(bcd_in[BCD_W*i +: BCD_W]);
         out_val += wt * (dig_neg[i] ? -longint'(m) : longint'(m));
         wt      *= RADIX;
      end
      out_val += wt * longint'(carry_top);
      if (all_bcd) begin
         assert_reconstruct_R7: assert (out_val == in_val)
            else $error("recoded operand differs from input");
      end
   end
endmodule

// File: tb/decimal_digit_recoder_test.sv
module decimal_digit_recoder_test;
   localparam int CLK_PERIOD = 10;
   localparam int ND = 4;
   localparam int NV = 6;

   // Directed table: operand, expected signed digits (4-bit two's complement, msd first), carry
   localparam logic [15:0] VIN [NV] = '{16'h0000, 16'h9999, 16'h5555, 16'h6666, 16'h1234, 16'h4959};
   localparam logic [15:0] VDIG[NV] = '{16'h0000, 16'h000F, 16'h5555, 16'hDDDC, 16'h1234, 16'h50CF};
   localparam logic        VCAR[NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};

   logic clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [4*ND-1:0] bcd_in;
   logic [ND-1:0]   dig_neg;
   logic [5*ND-1:0] dig_sel;
   logic            carry_top;

   int checks = 0;
   int fails  = 0;

   decimal_digit_recoder #(.NDIG(ND)) uut (
      .bcd_in    (bcd_in),
      .dig_neg   (dig_neg),
      .dig_sel   (dig_sel),
      .carry_top (carry_top)
   );

   function automatic logic [5:0] enc(input int v);   // {neg, sel} per R2/R3/R4
      logic [5:0] r;
      int m;
      m = (v < 0) ? -v : v;
      r = '0;
      r[5] = (v < 0);
      if (m > 0) r[m-1] = 1'b1;
      return r;
   endfunction

   function automatic int dec_sel(input logic [4:0] s);
      int m;
      m = -1;
      case (s)
         5'b00000: m = 0;
         5'b00001: m = 1;
         5'b00010: m = 2;
         5'b00100: m = 3;
         5'b01000: m = 4;
         5'b10000: m = 5;
         default:  m = -1;
      endcase
      return m;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic apply(input logic [15:0] v);
      @(posedge clk);
      bcd_in = v;
      @(negedge clk);
   endtask

   initial begin
      bcd_in = '0;
      // reset state: zero operand
      apply(16'h0000);
      check(dig_sel == '0 && dig_neg == '0, "R3", "zero operand lines", {dig_neg, dig_sel}, 0);
      check(carry_top == 1'b0, "R6", "zero operand carry", carry_top, 0);

      // directed table
      for (int t = 0; t < NV; t++) begin
         logic [5*ND-1:0] es;
         logic [ND-1:0]   en;
         apply(VIN[t]);
         for (int i = 0; i < ND; i++) begin
            logic [5:0] e;
            e = enc(int'($signed(VDIG[t][4*i +: 4])));
            en[i] = e[5];
            es[5*i +: 5] = e[4:0];
         end
         check(dig_sel == es, "R2", $sformatf("table %0d select", t), dig_sel, es);
         check(dig_neg == en, "R4", $sformatf("table %0d sign", t), dig_neg, en);
         check(carry_top == VCAR[t], "R7", $sformatf("table %0d carry", t), carry_top, VCAR[t]);
      end

      // exhaustive legal operands against the transfer rule of R5
      for (int n = 0; n < 10000; n++) begin
         logic [15:0] v;
         int x, d, tsum, dv, m, dsum, rec;
         int bad_fmt;
         int mism;
         for (int i = 0; i < ND; i++) v[4*i +: 4] = 4'((n / (10 ** i)) % 10);
         apply(v);
         x = 0; rec = 0; bad_fmt = 0; mism = 0;
         for (int i = 0; i < ND; i++) begin
            logic [5:0] e;
            d    = int'(v[4*i +: 4]);
            tsum = d + x;   // R6: x starts at 0
            if (tsum >= 6) begin dv = tsum - 10; x = 1; end
            else           begin dv = tsum;      x = 0; end
            e = enc(dv);
            if ({dig_neg[i], dig_sel[5*i +: 5]} != e) mism++;
            m = dec_sel(dig_sel[5*i +: 5]);
            if (m < 0 || (m == 0 && dig_neg[i])) bad_fmt++;
            else begin
               dsum = dig_neg[i] ? -m : m;
               rec += dsum * (10 ** i);
            end
         end
         if (carry_top != x[0]) mism++;
         rec += int'(carry_top) * 10000;
         check(mism == 0, "R5", $sformatf("operand %0d digits", n), mism, 0);
         check(bad_fmt == 0, "R1", $sformatf("operand %0d format", n), bad_fmt, 0);
         check(rec == n, "R7", $sformatf("operand %0d value", n), rec, n);
      end

      // corner cases
      apply(16'h0005);
      check(dig_sel[4:0] == 5'b10000 && !dig_neg[0] && dig_sel[19:5] == '0, "R5",
            "five stays positive", dig_sel, 20'h00010);
      apply(16'h0006);
      check(dig_sel[4:0] == 5'b01000 && dig_neg[0] && dig_sel[9:5] == 5'b00001, "R5",
            "six becomes -4 plus transfer", dig_sel, 20'h00028);
      apply(16'h9000);
      check(carry_top && dig_neg[3] && dig_sel[19:15] == 5'b00001, "R8",
            "top digit nine", {carry_top, dig_neg[3], dig_sel[19:15]}, 7'b1100001);
      apply(16'h0009);
      check(dig_sel[9:5] == 5'b00001 && !dig_neg[1], "R8",
            "nine at digit 0 gives +1 at digit 1", dig_sel[9:5], 1);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule